// File: doc/BRIEF.md
# D-Left Bucket Allocator

This block places new flow keys into a table split into D equal sub-tables. Each sub-table has W buckets, and each bucket has H slots. Every key arrives with D bucket indices, one per sub-table, which hash logic upstream has already computed. The block looks at how many slots each candidate bucket has in use. It chooses the bucket with the lowest count. If counts are equal, the candidate from the lower sub-table number wins. The block then claims the lowest free slot in that bucket, reports where the key went and raises that bucket's count. When every candidate is full, it rejects the key instead.

The occupancy state is updated one clock after the decision is made. Keys can arrive on consecutive cycles, so the comparison must include any update still in flight. Both the pending allocation and a pending slot release are forwarded into it. An eviction engine releases slots through a separate free port. The key input uses a valid/ready handshake. It holds the key back for one cycle when a release aimed at one of that key's candidate buckets arrives in the same cycle.

The control has two states. ST_IDLE means no decision is waiting to be written back. ST_COMMIT means one is waiting. An accepted key always moves the machine to ST_COMMIT, whatever the current state. A cycle with no accepted key moves it to ST_IDLE.

Top module: `dlh_bucket_alloc`

## Requirements
- R1: After reset, key_ready is high, res_valid is low and every bucket is empty.
- R2: A key is placed in the candidate bucket that has the fewest occupied slots.
- R3: When candidates are equally loaded, the one with the lower sub-table number wins. res_tbl gives that number, and 0 is the leftmost sub-table.
- R4: Inside the chosen bucket, the lowest-numbered free slot is claimed.
- R5: When every candidate holds H keys, the result has res_valid and res_reject both high. No slot is claimed and no count changes.
- R6: A key accepted at clock edge t produces its result at edge t+1, carrying the same key. res_valid is high in no other cycle.
- R7: A key accepted right after another key sees that key's pending allocation, both in the load comparison and in the slot choice.
- R8: A free releases one slot, so the bucket's load drops by one for every key accepted after the edge that captured the free. A free that names an unoccupied slot has no effect.
- R9: key_ready is low in exactly those cycles where free_valid names one of the presented key's candidate buckets. A key accepted in the next cycle can claim the released slot.
- R10: key_cand carries candidate k in bits [k*IDX_W +: IDX_W], where IDX_W = log2(W).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Key offered |
| key_ready | output | 1 | Key can be taken this cycle |
| key_id | input | KEY_W | Key tag, returned with the result |
| key_cand | input | D*IDX_W | Candidate bucket index for each sub-table |
| free_valid | input | 1 | Release one slot |
| free_tbl | input | TBL_W | Sub-table of the slot to release |
| free_idx | input | IDX_W | Bucket of the slot to release |
| free_slot | input | SLOT_W | Slot to release |
| res_valid | output | 1 | Result present |
| res_reject | output | 1 | All candidates were full |
| res_key | output | KEY_W | Key tag of the result |
| res_tbl | output | TBL_W | Chosen sub-table |
| res_idx | output | IDX_W | Chosen bucket |
| res_slot | output | SLOT_W | Claimed slot |

## Verification
The assertions check on every cycle that results arrive with the right latency and carry the right key, and that a reject is always a valid result. They also check that two results in a row for the same bucket never report the same slot, and that key_ready drops only when a free is present. Choosing the least-loaded candidate, breaking ties to the left, the lowest-slot rule, rejects when all candidates are full, and slot reuse after a free all depend on the history of occupancy. Only the bench's scenarios can show these, by tracking the expected load of each bucket.

// File: rtl/dlh_pkg.sv
`timescale 1ns/1ps
package dlh_pkg;
    typedef enum logic {
        ST_IDLE,
        ST_COMMIT
    } dlh_state_e;
endpackage

// File: rtl/dlh_occ_store.sv
`timescale 1ns/1ps
// Per-bucket slot mask and occupancy count, updated one edge after a decision.
module dlh_occ_store #(
    parameter int NB     = 16,
    parameter int H      = 8,
    parameter int CNT_W  = 4,
    parameter int B_W    = 4,
    parameter int SLOT_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc_en,
    input  logic [B_W-1:0]      inc_bkt,
    input  logic [SLOT_W-1:0]   inc_slot,
    input  logic                dec_en,
    input  logic [B_W-1:0]      dec_bkt,
    input  logic [SLOT_W-1:0]   dec_slot,
    output logic [NB*H-1:0]     mask_flat,
    output logic [NB*CNT_W-1:0] cnt_flat
);
    for (genvar b = 0; b < NB; b++) begin : g_bkt
        logic [H-1:0]     mask_q;
        logic [CNT_W-1:0] cnt_q;
        logic             inc_hit;
        logic             dec_hit;
        logic [H-1:0]     inc_bit;
        logic [H-1:0]     dec_bit;

        always_comb begin
            inc_hit = inc_en && (inc_bkt == B_W'(b));
            dec_hit = dec_en && (dec_bkt == B_W'(b)) && mask_q[dec_slot];
            inc_bit = inc_hit ? (H'(1) << inc_slot) : '0;
            dec_bit = dec_hit ? (H'(1) << dec_slot) : '0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q <= '0;
                cnt_q  <= '0;
            end else begin
                mask_q <= (mask_q & ~dec_bit) | inc_bit;
                case ({inc_hit, dec_hit})
                    2'b10:   cnt_q <= cnt_q + 1'b1;
                    2'b01:   cnt_q <= cnt_q - 1'b1;
                    default: cnt_q <= cnt_q;
                endcase
            end
        end

        assign mask_flat[b*H +: H]         = mask_q;
        assign cnt_flat[b*CNT_W +: CNT_W]  = cnt_q;
    end
endmodule

// File: rtl/dlh_load_view.sv
`timescale 1ns/1ps
// Occupancy of one candidate bucket as it will be after the pending write-back.
module dlh_load_view #(
    parameter int H      = 8,
    parameter int CNT_W  = 4,
    parameter int B_W    = 4,
    parameter int SLOT_W = 3
) (
    input  logic [B_W-1:0]    cand_bkt,
    input  logic [H-1:0]      base_mask,
    input  logic [CNT_W-1:0]  base_cnt,
    input  logic              inc_en,
    input  logic [B_W-1:0]    inc_bkt,
    input  logic [SLOT_W-1:0] inc_slot,
    input  logic              dec_en,
    input  logic [B_W-1:0]    dec_bkt,
    input  logic [SLOT_W-1:0] dec_slot,
    output logic [H-1:0]      view_mask,
    output logic [CNT_W-1:0]  view_cnt
);
    logic         inc_hit;
    logic         dec_hit;
    logic [H-1:0] inc_bit;
    logic [H-1:0] dec_bit;

    always_comb begin
        inc_hit   = inc_en && (inc_bkt == cand_bkt);
        dec_hit   = dec_en && (dec_bkt == cand_bkt) && base_mask[dec_slot];
        inc_bit   = inc_hit ? (H'(1) << inc_slot) : '0;
        dec_bit   = dec_hit ? (H'(1) << dec_slot) : '0;
        view_mask = (base_mask & ~dec_bit) | inc_bit;
        case ({inc_hit, dec_hit})
            2'b10:   view_cnt = base_cnt + 1'b1;
            2'b01:   view_cnt = base_cnt - 1'b1;
            default: view_cnt = base_cnt;
        endcase
    end
endmodule

// File: rtl/dlh_pick.sv
`timescale 1ns/1ps
// Least-loaded candidate with left preference, then lowest free slot.
module dlh_pick #(
    parameter int D      = 2,
    parameter int H      = 8,
    parameter int CNT_W  = 4,
    parameter int TBL_W  = 1,
    parameter int SLOT_W = 3
) (
    input  logic [D*CNT_W-1:0] view_cnt_flat,
    input  logic [D*H-1:0]     view_mask_flat,
    output logic [TBL_W-1:0]   win_tbl,
    output logic               all_full,
    output logic [SLOT_W-1:0]  pick_slot
);
    logic [CNT_W-1:0] best;
    logic [H-1:0]     sel_mask;

    always_comb begin
        best    = view_cnt_flat[0 +: CNT_W];
        win_tbl = '0;
        for (int k = 1; k < D; k++) begin
            if (view_cnt_flat[k*CNT_W +: CNT_W] < best) begin
                best    = view_cnt_flat[k*CNT_W +: CNT_W];
                win_tbl = TBL_W'(k);
            end
        end
        all_full  = (best >= CNT_W'(H));
        sel_mask  = view_mask_flat[win_tbl*H +: H];
        pick_slot = '0;
        for (int s = H - 1; s >= 0; s--) begin
            if (!sel_mask[s]) pick_slot = SLOT_W'(s);
        end
    end
endmodule

// File: rtl/dlh_bucket_alloc.sv
`timescale 1ns/1ps
module dlh_bucket_alloc #(
    parameter int D     = 2,
    parameter int W     = 8,
    parameter int H     = 8,
    parameter int KEY_W = 16,
    localparam int IDX_W  = (W > 1) ? $clog2(W) : 1,
    localparam int TBL_W  = (D > 1) ? $clog2(D) : 1,
    localparam int SLOT_W = (H > 1) ? $clog2(H) : 1,
    localparam int CNT_W  = $clog2(H + 1),
    localparam int NB     = D * W,
    localparam int B_W    = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               key_valid,
    output logic               key_ready,
    input  logic [KEY_W-1:0]   key_id,
    input  logic [D*IDX_W-1:0] key_cand,
    input  logic               free_valid,
    input  logic [TBL_W-1:0]   free_tbl,
    input  logic [IDX_W-1:0]   free_idx,
    input  logic [SLOT_W-1:0]  free_slot,
    output logic               res_valid,
    output logic               res_reject,
    output logic [KEY_W-1:0]   res_key,
    output logic [TBL_W-1:0]   res_tbl,
    output logic [IDX_W-1:0]   res_idx,
    output logic [SLOT_W-1:0]  res_slot
);
    import dlh_pkg::*;

    function automatic logic [B_W-1:0] gidx(input logic [TBL_W-1:0] t,
                                           input logic [IDX_W-1:0] i);
        return B_W'(t) * B_W'(W) + B_W'(i);
    endfunction

    dlh_state_e state_q, state_nx;

    logic               accept;
    logic               hazard;
    logic [B_W-1:0]     free_gbkt;
    logic [B_W-1:0]     cand_bkt [D];

    logic [KEY_W-1:0]   pend_key;
    logic [TBL_W-1:0]   pend_tbl;
    logic [IDX_W-1:0]   pend_idx;
    logic [SLOT_W-1:0]  pend_slot;
    logic [B_W-1:0]     pend_bkt;
    logic               pend_reject;
    logic               inc_en;

    logic               dpend_valid;
    logic [B_W-1:0]     dpend_bkt;
    logic [SLOT_W-1:0]  dpend_slot;

    logic [NB*H-1:0]     mask_flat;
    logic [NB*CNT_W-1:0] cnt_flat;
    logic [D*H-1:0]      view_mask_flat;
    logic [D*CNT_W-1:0]  view_cnt_flat;

    logic [TBL_W-1:0]   win_tbl;
    logic               all_full;
    logic [SLOT_W-1:0]  pick_slot;
    logic [B_W-1:0]     win_bkt;
    logic [IDX_W-1:0]   win_idx;

    assign free_gbkt = gidx(free_tbl, free_idx);
    assign inc_en    = (state_q == ST_COMMIT) && !pend_reject;

    for (genvar k = 0; k < D; k++) begin : g_cand
        assign cand_bkt[k] = gidx(TBL_W'(k), key_cand[k*IDX_W +: IDX_W]);

        dlh_load_view #(
            .H(H), .CNT_W(CNT_W), .B_W(B_W), .SLOT_W(SLOT_W)
        ) u_view (
            .cand_bkt  (cand_bkt[k]),
            .base_mask (mask_flat[cand_bkt[k]*H +: H]),
            .base_cnt  (cnt_flat[cand_bkt[k]*CNT_W +: CNT_W]),
            .inc_en    (inc_en),
            .inc_bkt   (pend_bkt),
            .inc_slot  (pend_slot),
            .dec_en    (dpend_valid),
            .dec_bkt   (dpend_bkt),
            .dec_slot  (dpend_slot),
            .view_mask (view_mask_flat[k*H +: H]),
            .view_cnt  (view_cnt_flat[k*CNT_W +: CNT_W])
        );
    end

    dlh_pick #(
        .D(D), .H(H), .CNT_W(CNT_W), .TBL_W(TBL_W), .SLOT_W(SLOT_W)
    ) u_pick (
        .view_cnt_flat  (view_cnt_flat),
        .view_mask_flat (view_mask_flat),
        .win_tbl        (win_tbl),
        .all_full       (all_full),
        .pick_slot      (pick_slot)
    );

    assign win_bkt = cand_bkt[win_tbl];
    assign win_idx = key_cand[win_tbl*IDX_W +: IDX_W];

    dlh_occ_store #(
        .NB(NB), .H(H), .CNT_W(CNT_W), .B_W(B_W), .SLOT_W(SLOT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_en    (inc_en),
        .inc_bkt   (pend_bkt),
        .inc_slot  (pend_slot),
        .dec_en    (dpend_valid),
        .dec_bkt   (dpend_bkt),
        .dec_slot  (dpend_slot),
        .mask_flat (mask_flat),
        .cnt_flat  (cnt_flat)
    );

    // A release aimed at a candidate bucket is not yet visible to the view.
    always_comb begin
        hazard = 1'b0;
        for (int k = 0; k < D; k++) begin
            if (free_valid && (cand_bkt[k] == free_gbkt)) hazard = 1'b1;
        end
    end

    // Next state and handshake.
    always_comb begin
        key_ready = !hazard;
        accept    = key_valid && key_ready;
        state_nx  = state_q;
        unique case (state_q)
            ST_IDLE:   state_nx = accept ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_nx = accept ? ST_COMMIT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Decision capture and release capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_key    <= '0;
            pend_tbl    <= '0;
            pend_idx    <= '0;
            pend_slot   <= '0;
            pend_bkt    <= '0;
            pend_reject <= 1'b0;
            dpend_valid <= 1'b0;
            dpend_bkt   <= '0;
            dpend_slot  <= '0;
        end else begin
            if (accept) begin
                pend_key    <= key_id;
                pend_tbl    <= win_tbl;
                pend_idx    <= win_idx;
                pend_slot   <= pick_slot;
                pend_bkt    <= win_bkt;
                pend_reject <= all_full;
            end
            dpend_valid <= free_valid;
            dpend_bkt   <= free_gbkt;
            dpend_slot  <= free_slot;
        end
    end

    // Result outputs, registered with the write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_reject <= 1'b0;
            res_key    <= '0;
            res_tbl    <= '0;
            res_idx    <= '0;
            res_slot   <= '0;
        end else begin
            res_valid  <= (state_q == ST_COMMIT);
            res_reject <= (state_q == ST_COMMIT) && pend_reject;
            res_key    <= pend_key;
            res_tbl    <= pend_tbl;
            res_idx    <= pend_idx;
            res_slot   <= pend_slot;
        end
    end
endmodule

// File: rtl/dlh_bucket_alloc_chk.sv
`timescale 1ns/1ps
module dlh_bucket_alloc_chk #(
    parameter int KEY_W  = 16,
    parameter int TBL_W  = 1,
    parameter int IDX_W  = 3,
    parameter int SLOT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_valid,
    input logic              key_ready,
    input logic [KEY_W-1:0]  key_id,
    input logic              free_valid,
    input logic              res_valid,
    input logic              res_reject,
    input logic [KEY_W-1:0]  res_key,
    input logic [TBL_W-1:0]  res_tbl,
    input logic [IDX_W-1:0]  res_idx,
    input logic [SLOT_W-1:0] res_slot
);
    logic acc;
    logic alloc;
    assign acc   = key_valid && key_ready;
    assign alloc = res_valid && !res_reject;

    assert_result_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> ##2 (res_valid && (res_key == $past(key_id, 2))));

    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(acc, 2));

    assert_reject_is_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_reject |-> res_valid);

    assert_distinct_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && $past(alloc) && (res_tbl == $past(res_tbl)) && (res_idx == $past(res_idx)))
        |-> (res_slot != $past(res_slot)));

    assert_stall_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && !key_ready) |-> free_valid);
endmodule

bind dlh_bucket_alloc dlh_bucket_alloc_chk #(
    .KEY_W(KEY_W), .TBL_W(TBL_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_valid  (key_valid),
    .key_ready  (key_ready),
    .key_id     (key_id),
    .free_valid (free_valid),
    .res_valid  (res_valid),
    .res_reject (res_reject),
    .res_key    (res_key),
    .res_tbl    (res_tbl),
    .res_idx    (res_idx),
    .res_slot   (res_slot)
);

// File: tb/dlh_bucket_alloc_bench.sv
`timescale 1ns/1ps
module dlh_bucket_alloc_bench;
    localparam int D = 2, W = 8, H = 8, KEY_W = 16;
    localparam int IDX_W = 3, TBL_W = 1, SLOT_W = 3;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               key_valid;
    logic               key_ready;
    logic [KEY_W-1:0]   key_id;
    logic [D*IDX_W-1:0] key_cand;
    logic               free_valid;
    logic [TBL_W-1:0]   free_tbl;
    logic [IDX_W-1:0]   free_idx;
    logic [SLOT_W-1:0]  free_slot;
    logic               res_valid;
    logic               res_reject;
    logic [KEY_W-1:0]   res_key;
    logic [TBL_W-1:0]   res_tbl;
    logic [IDX_W-1:0]   res_idx;
    logic [SLOT_W-1:0]  res_slot;

    int n_checks = 0;
    int n_err    = 0;

    always #2.5 clk = ~clk;

    dlh_bucket_alloc #(.D(D), .W(W), .H(H), .KEY_W(KEY_W)) u_dlh_bucket_alloc (
        .clk(clk), .rst_n(rst_n),
        .key_valid(key_valid), .key_ready(key_ready), .key_id(key_id), .key_cand(key_cand),
        .free_valid(free_valid), .free_tbl(free_tbl), .free_idx(free_idx), .free_slot(free_slot),
        .res_valid(res_valid), .res_reject(res_reject), .res_key(res_key),
        .res_tbl(res_tbl), .res_idx(res_idx), .res_slot(res_slot)
    );

    // Fields: cand0, cand1, reject, table, bucket, slot (back-to-back stream).
    localparam logic [13:0] VEC [10] = '{
        {3'd0, 3'd0, 1'b0, 1'b0, 3'd0, 3'd0},
        {3'd0, 3'd0, 1'b0, 1'b1, 3'd0, 3'd0},
        {3'd0, 3'd0, 1'b0, 1'b0, 3'd0, 3'd1},
        {3'd0, 3'd0, 1'b0, 1'b1, 3'd0, 3'd1},
        {3'd1, 3'd0, 1'b0, 1'b0, 3'd1, 3'd0},
        {3'd2, 3'd0, 1'b0, 1'b0, 3'd2, 3'd0},
        {3'd0, 3'd3, 1'b0, 1'b1, 3'd3, 3'd0},
        {3'd3, 3'd3, 1'b0, 1'b0, 3'd3, 3'd0},
        {3'd3, 3'd3, 1'b0, 1'b0, 3'd3, 3'd1},
        {3'd3, 3'd3, 1'b0, 1'b1, 3'd3, 3'd1}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_res(input string tag, input bit rej, input int t, input int i,
                             input int s, input int key);
        check({tag, " valid"}, int'(res_valid), 1);
        check({tag, " reject"}, int'(res_reject), int'(rej));
        check({tag, " key"}, int'(res_key), key);
        if (!rej) begin
            check({tag, " table"}, int'(res_tbl), t);
            check({tag, " bucket"}, int'(res_idx), i);
            check({tag, " slot"}, int'(res_slot), s);
        end
    endtask

    // One key alone; returns at the negedge where its result is visible.
    task automatic send(input int c0, input int c1, input int key);
        @(negedge clk);
        key_valid = 1'b1;
        key_id    = KEY_W'(key);
        key_cand  = {IDX_W'(c1), IDX_W'(c0)};
        @(posedge clk);
        @(negedge clk);
        key_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_free(input int t, input int i, input int s);
        @(negedge clk);
        free_valid = 1'b1;
        free_tbl   = TBL_W'(t);
        free_idx   = IDX_W'(i);
        free_slot  = SLOT_W'(s);
        @(posedge clk);
        @(negedge clk);
        free_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 50000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; key_valid = 1'b0; key_id = '0; key_cand = '0;
        free_valid = 1'b0; free_tbl = '0; free_idx = '0; free_slot = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", int'(key_ready), 1);
        check("R1 no result after reset", int'(res_valid), 0);

        // R2 R3 R4 R7 R10: back-to-back stream, result visible two negedges later.
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                logic [13:0] v;
                v = VEC[i-2];
                check_res("R2/R3/R4/R7 stream", v[7], int'(v[6]), int'(v[5:3]),
                          int'(v[2:0]), 16'h100 + i - 2);
            end
            if (i < 10) begin
                key_valid = 1'b1;
                key_id    = KEY_W'(16'h100 + i);
                key_cand  = {VEC[i][10:8], VEC[i][13:11]};
            end else begin
                key_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R6 no result without key", int'(res_valid), 0);

        // R5: fill both candidate buckets, then reject.
        for (int k = 0; k < 16; k++) begin
            send(5, 5, 16'h200 + k);
            check_res("R5 fill", 1'b0, k % 2, 5, k / 2, 16'h200 + k);
        end
        send(5, 5, 16'h300);
        check_res("R5 reject", 1'b1, 0, 0, 0, 16'h300);
        send(5, 5, 16'h301);
        check_res("R5 reject again", 1'b1, 0, 0, 0, 16'h301);
        send(5, 6, 16'h302);
        check_res("R5 other candidate", 1'b0, 1, 6, 0, 16'h302);

        // R8: release inside a full bucket, then reuse.
        do_free(0, 5, 2);
        send(5, 5, 16'h303);
        check_res("R8 reuse after free", 1'b0, 0, 5, 2, 16'h303);
        do_free(0, 3, 0);
        send(3, 3, 16'h304);
        check_res("R8 load drop", 1'b0, 0, 3, 0, 16'h304);

        // R8: free of an empty slot leaves load unchanged.
        do_free(0, 2, 5);
        send(2, 6, 16'h305);
        check_res("R8 empty free tie", 1'b0, 0, 2, 1, 16'h305);
        send(2, 6, 16'h306);
        check_res("R8 empty free count", 1'b0, 1, 6, 1, 16'h306);

        // R9: release aimed at a candidate stalls the key for one cycle.
        @(negedge clk);
        key_valid = 1'b1; key_id = 16'h307; key_cand = {3'd3, 3'd0};
        free_valid = 1'b1; free_tbl = 1'b0; free_idx = 3'd0; free_slot = 3'd0;
        #1;
        check("R9 stall on colliding free", int'(key_ready), 0);
        @(posedge clk);
        @(negedge clk);
        free_valid = 1'b0;
        #1;
        check("R9 ready after free", int'(key_ready), 1);
        @(posedge clk);
        @(negedge clk);
        key_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_res("R9 freed slot claimed", 1'b0, 0, 0, 0, 16'h307);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule